// File: doc/BRIEF.md
# PWM Compare and Action Qualifier

This block turns a running time-base count into two pulse-width-modulated outputs. An external counter supplies its present value, a count direction, a qualifier that marks the cycles on which the counter advances, and two event strobes: one for reaching zero and one for reaching the period value. Each channel owns a 16-bit compare value. When the count matches a compare value, a compare event fires. Each output owns an action word that gives every event a two-bit action. The action may leave the output alone, drive it low, drive it high or invert it.

Compare values can be written straight into the active comparator. They can also be parked in a buffer and copied on a chosen counter event, so that a new duty value never takes effect in the middle of a period. A continuous software-force word can pin either output low or high for as long as it stays set. The action state underneath keeps evolving while the force is held. Everything is reached through a 16-bit register port with byte addresses, writes taking effect on the clock edge and reads returning combinationally.

Top module: `pwm_cmp_aq`

## Requirements
- R1: After reset both outputs are low and every register reads zero.
- R2: Registers are at byte addresses 0x0E (compare control), 0x12 and 0x14 (compare A and B), 0x16 and 0x18 (action A and B), and 0x1C (force). Unused bits read zero, so the masks are 0x005F for compare control, 0x0FFF for action words and 0x000F for force. A compare register reads back its active value.
- R3: Action word fields are: bits 1:0 for the zero event, 3:2 for the period event, 5:4 for compare A counting up, 7:6 for compare A counting down, 9:8 for compare B counting up, and 11:10 for compare B counting down. Codes are 0 none, 1 low, 2 high, 3 toggle.
- R4: With the zero action set to high and the compare-up action set to low, the output is high from the zero tick until the tick at which the count equals the compare value.
- R5: A compare value of 0 under the R4 setup keeps the output low for the whole period.
- R6: Compare control bit 4 (A) and bit 6 (B) select shadow mode; with the bit at 0 a write updates the active value at once. In shadow mode the active value is loaded from the buffer on the event chosen by bits 1:0 (A) or 3:2 (B): 0 zero, 1 period, 2 either.
- R7: Load select 3 in shadow mode never loads; the active value holds through zero and period events.
- R8: Toggle inverts the output; compare events use the down fields only while counting down and the up fields only while counting up.
- R9: When several events with non-zero actions coincide on one tick, the order of priority is compare B, then compare A, then period, then zero; an event coded "no action" does not mask a lower one.
- R10: Actions are taken only on cycles where the tick input is high.
- R11: Force field bits 2n+1:2n (n=0 for A, 1 for B) give 1 hold low, 2 hold high, 0 or 3 no force; the underlying action state keeps updating while forced and shows once the force is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for addr_i |
| tick_i | input | 1 | Time-base advance qualifier |
| cnt_i | input | 16 | Time-base count value |
| zero_i | input | 1 | Count-equals-zero event |
| period_i | input | 1 | Count-equals-period event |
| cnt_up_i | input | 1 | Count direction, 1 = up |
| pwm_o | output | 2 | Outputs, bit 0 = A, bit 1 = B |

## Verification
The hardest cases to reach are coincident events: compare A, compare B and zero or period landing on the same tick. A free-running counter reaches these only with particular compare settings. The bench therefore drives count, direction and event strobes directly, one tick at a time. This lets it place every coincidence and every shadow load exactly, and read compare registers back between ticks to see when the active value moves.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int DW  = 16;
  localparam int AW  = 8;
  localparam int NCH = 2;
  localparam int AQ_BITS = 12;

  localparam logic [AW-1:0] ADDR_CTL   = 8'h0E;
  localparam logic [AW-1:0] ADDR_CMP0  = 8'h12;
  localparam logic [AW-1:0] ADDR_AQ0   = 8'h16;
  localparam logic [AW-1:0] ADDR_FORCE = 8'h1C;

  typedef enum logic [1:0] {ACT_NONE, ACT_LOW, ACT_HIGH, ACT_TOG} act_e;
  typedef enum logic [1:0] {LD_ZERO, LD_PRD, LD_EITHER, LD_FROZEN} load_e;
  typedef enum logic [1:0] {FRC_OFF, FRC_LOW, FRC_HIGH, FRC_RSVD} frc_e;

  function automatic logic [DW-1:0] ctl_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int c = 0; c < NCH; c++) begin
      m[2*c +: 2] = 2'b11;
      m[4 + 2*c]  = 1'b1;
    end
    return m;
  endfunction

  localparam logic [DW-1:0] CTL_MASK   = ctl_mask();
  localparam logic [DW-1:0] AQ_MASK    = DW'((1 << AQ_BITS) - 1);
  localparam logic [DW-1:0] FORCE_MASK = DW'((1 << (2*NCH)) - 1);
endpackage

// File: rtl/pwm_cmp_reg.sv
module pwm_cmp_reg
  import pwm_aq_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         shadow_en_i,
  input  load_e        load_sel_i,
  input  logic         tick_i,
  input  logic         zero_i,
  input  logic         period_i,
  output logic [W-1:0] cmp_o
);
  logic [W-1:0] buf_q, act_q;
  logic         load_hit;

  always_comb begin
    unique case (load_sel_i)
      LD_ZERO:   load_hit = zero_i;
      LD_PRD:    load_hit = period_i;
      LD_EITHER: load_hit = zero_i | period_i;
      default:   load_hit = 1'b0;
    endcase
    load_hit = load_hit & tick_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_i) buf_q <= wdata_i;
      if (wr_i && !shadow_en_i)          act_q <= wdata_i;
      else if (shadow_en_i && load_hit)  act_q <= buf_q;
    end
  end

  assign cmp_o = act_q;

  a_r6_immediate_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !shadow_en_i) |=> (cmp_o == $past(wdata_i)));

  a_r7_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shadow_en_i && load_sel_i == LD_FROZEN) |=> $stable(cmp_o));
endmodule

// File: rtl/pwm_act_qual.sv
module pwm_act_qual
  import pwm_aq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               zero_i,
  input  logic               period_i,
  input  logic               cnt_up_i,
  input  logic               ca_hit_i,
  input  logic               cb_hit_i,
  input  logic [AQ_BITS-1:0] ctl_i,
  input  frc_e               frc_i,
  output logic               out_o
);
  localparam int NEV = 6;
  logic [NEV-1:0] ev;
  act_e           code;
  logic           aq_q;

  // event order is ascending priority: zero, period, A up, A down, B up, B down
  assign ev = {cb_hit_i & ~cnt_up_i, cb_hit_i & cnt_up_i,
               ca_hit_i & ~cnt_up_i, ca_hit_i & cnt_up_i,
               period_i, zero_i};

  always_comb begin
    code = ACT_NONE;
    for (int e = 0; e < NEV; e++)
      if (ev[e] && ctl_i[2*e +: 2] != 2'b00) code = act_e'(ctl_i[2*e +: 2]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) aq_q <= 1'b0;
    else if (tick_i) begin
      unique case (code)
        ACT_LOW:  aq_q <= 1'b0;
        ACT_HIGH: aq_q <= 1'b1;
        ACT_TOG:  aq_q <= ~aq_q;
        default:  aq_q <= aq_q;
      endcase
    end
  end

  always_comb begin
    unique case (frc_i)
      FRC_LOW:  out_o = 1'b0;
      FRC_HIGH: out_o = 1'b1;
      default:  out_o = aq_q;
    endcase
  end

  a_r10_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(aq_q));

  a_r9_cmpb_beats_cmpa: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_up_i && ca_hit_i && cb_hit_i && ctl_i[9:8] == 2'b01) |=> !aq_q);

  a_r11_force_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frc_i == FRC_HIGH) |-> out_o);

  a_r11_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frc_i == FRC_LOW) |-> !out_o);
endmodule

// File: rtl/pwm_cmp_aq.sv
module pwm_cmp_aq
  import pwm_aq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          tick_i,
  input  logic [DW-1:0] cnt_i,
  input  logic          zero_i,
  input  logic          period_i,
  input  logic          cnt_up_i,
  output logic [NCH-1:0] pwm_o
);
  logic [DW-1:0] ctl_q, frc_q;
  logic [DW-1:0] aq_q  [NCH];
  logic [DW-1:0] cmp_v [NCH];
  logic [NCH-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      frc_q <= '0;
      for (int c = 0; c < NCH; c++) aq_q[c] <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADDR_CTL)   ctl_q <= wdata_i & CTL_MASK;
      if (addr_i == ADDR_FORCE) frc_q <= wdata_i & FORCE_MASK;
      for (int c = 0; c < NCH; c++)
        if (addr_i == AW'(ADDR_AQ0 + 2*c)) aq_q[c] <= wdata_i & AQ_MASK;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTL)   rdata_o = ctl_q;
    if (addr_i == ADDR_FORCE) rdata_o = frc_q;
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == AW'(ADDR_CMP0 + 2*c)) rdata_o = cmp_v[c];
      if (addr_i == AW'(ADDR_AQ0 + 2*c))  rdata_o = aq_q[c];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    localparam logic [AW-1:0] MY_ADDR = AW'(ADDR_CMP0 + 2*g);
    pwm_cmp_reg #(.W(DW)) u_cmp (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr_en_i && addr_i == MY_ADDR),
      .wdata_i     (wdata_i),
      .shadow_en_i (ctl_q[4 + 2*g]),
      .load_sel_i  (load_e'(ctl_q[2*g +: 2])),
      .tick_i      (tick_i),
      .zero_i      (zero_i),
      .period_i    (period_i),
      .cmp_o       (cmp_v[g])
    );
    assign hit[g] = (cnt_i == cmp_v[g]);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_aq
    pwm_act_qual u_aq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .zero_i   (zero_i),
      .period_i (period_i),
      .cnt_up_i (cnt_up_i),
      .ca_hit_i (hit[0]),
      .cb_hit_i (hit[1]),
      .ctl_i    (aq_q[g][AQ_BITS-1:0]),
      .frc_i    (frc_e'(frc_q[2*g +: 2])),
      .out_o    (pwm_o[g])
    );
  end

  a_r2_unused_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctl_q & ~CTL_MASK) == '0) && ((frc_q & ~FORCE_MASK) == '0));
endmodule

// File: tb/pwm_cmp_aq_bench.sv
module pwm_cmp_aq_bench;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, tick = 0, zero = 0, prd = 0, up = 1;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0, cnt = '0, rdata;
  logic [1:0]  pwm;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_cmp_aq u_pwm_cmp_aq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .cnt_i(cnt), .zero_i(zero), .period_i(prd),
    .cnt_up_i(up), .pwm_o(pwm));

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic step(logic [15:0] c, logic z, logic p, logic u, logic t);
    cnt = c; zero = z; prd = p; up = u; tick = t;
    @(posedge clk); @(negedge clk);
    tick = 0; zero = 0; prd = 0;
  endtask

  // both action states driven low via zero-clear
  task automatic settle_low();
    wr(8'h16, 16'h0001); wr(8'h18, 16'h0001);
    step(16'hFFFF, 1, 0, 1, 1);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 pwm", {14'd0, pwm}, 16'd0);
    foreach (u_addrs[i]) begin
      rd(u_addrs[i], d); chk("R1 reg", d, 16'd0);
    end
  endtask
  logic [7:0] u_addrs [6] = '{8'h0E, 8'h12, 8'h14, 8'h16, 8'h18, 8'h1C};

  task automatic t_masks();
    logic [15:0] d;
    wr(8'h16, 16'hFFFF); rd(8'h16, d); chk("R2 aqA mask", d, 16'h0FFF);
    wr(8'h0E, 16'hFFFF); rd(8'h0E, d); chk("R2 ctl mask", d, 16'h005F);
    wr(8'h1C, 16'hFFFF); rd(8'h1C, d); chk("R2 force mask", d, 16'h000F);
    wr(8'h1C, 16'h0000); wr(8'h0E, 16'h0000); wr(8'h16, 16'h0000);
    wr(8'h14, 16'h1234); rd(8'h14, d); chk("R2 cmpB readback", d, 16'h1234);
  endtask

  task automatic t_basic();
    settle_low();
    wr(8'h12, 16'd3); wr(8'h14, 16'd5);
    wr(8'h16, 16'h0012); wr(8'h18, 16'h0102);
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 8; c++) begin
        step(16'(c), c == 0, c == 7, 1, 1);
        chk("R4 A", {15'd0, pwm[0]}, {15'd0, c < 3});
        chk("R3 B up field", {15'd0, pwm[1]}, {15'd0, c < 5});
      end
  endtask

  task automatic t_zero_duty();
    wr(8'h12, 16'd0);
    for (int c = 0; c < 8; c++) begin
      step(16'(c), c == 0, c == 7, 1, 1);
      chk("R5 zero duty", {15'd0, pwm[0]}, 16'd0);
    end
  endtask

  task automatic t_shadow();
    logic [15:0] d;
    wr(8'h0E, 16'h0000); wr(8'h12, 16'd1); rd(8'h12, d); chk("R6 immediate", d, 16'd1);
    wr(8'h0E, 16'h0011); wr(8'h12, 16'd6);
    rd(8'h12, d); chk("R6 shadow held", d, 16'd1);
    step(16'd3, 0, 0, 1, 1); rd(8'h12, d); chk("R6 no event", d, 16'd1);
    step(16'd0, 1, 0, 1, 1); rd(8'h12, d); chk("R6 zero ignored", d, 16'd1);
    step(16'd7, 0, 1, 1, 1); rd(8'h12, d); chk("R6 period load", d, 16'd6);
    wr(8'h0E, 16'h0012); wr(8'h12, 16'd2);
    step(16'd0, 1, 0, 1, 1); rd(8'h12, d); chk("R6 either zero", d, 16'd2);
    wr(8'h12, 16'd4);
    step(16'd7, 0, 1, 1, 1); rd(8'h12, d); chk("R6 either period", d, 16'd4);
    wr(8'h0E, 16'h0040); wr(8'h14, 16'd9);
    step(16'd7, 0, 1, 1, 1); rd(8'h14, d); chk("R6 B zero-mode waits", d, 16'h1234 & 16'h0 | 16'd5);
    step(16'd0, 1, 0, 1, 1); rd(8'h14, d); chk("R6 B zero load", d, 16'd9);
  endtask

  task automatic t_frozen();
    logic [15:0] d;
    wr(8'h0E, 16'h0013); wr(8'h12, 16'd11);
    step(16'd0, 1, 0, 1, 1); step(16'd7, 0, 1, 1, 1);
    rd(8'h12, d); chk("R7 frozen", d, 16'd4);
    wr(8'h0E, 16'h0000);
  endtask

  task automatic t_toggle_down();
    settle_low();
    wr(8'h14, 16'd2); wr(8'h18, 16'h0C00);
    step(16'd2, 0, 0, 0, 1); chk("R8 toggle down", {15'd0, pwm[1]}, 16'd1);
    step(16'd2, 0, 0, 1, 1); chk("R8 up ignored", {15'd0, pwm[1]}, 16'd1);
    step(16'd1, 0, 0, 0, 1); chk("R8 no match", {15'd0, pwm[1]}, 16'd1);
    step(16'd2, 0, 0, 0, 1); chk("R8 toggle back", {15'd0, pwm[1]}, 16'd0);
    wr(8'h12, 16'd1); wr(8'h16, 16'h0008);
    step(16'd7, 0, 1, 1, 1); chk("R3 period field", {15'd0, pwm[0]}, 16'd1);
    wr(8'h16, 16'h0040);
    step(16'd1, 0, 0, 0, 1); chk("R3 A down field", {15'd0, pwm[0]}, 16'd0);
  endtask

  task automatic t_priority();
    settle_low();
    wr(8'h12, 16'd4); wr(8'h14, 16'd4);
    wr(8'h16, 16'h0120);
    step(16'd4, 0, 0, 1, 1); chk("R9 B over A", {15'd0, pwm[0]}, 16'd0);
    wr(8'h16, 16'h0020);
    step(16'd4, 0, 0, 1, 1); chk("R9 none does not mask", {15'd0, pwm[0]}, 16'd1);
    settle_low();
    wr(8'h16, 16'h0024);
    step(16'd4, 0, 1, 1, 1); chk("R9 compare over period", {15'd0, pwm[0]}, 16'd1);
    wr(8'h16, 16'h0006);
    step(16'd9, 1, 1, 1, 1); chk("R9 period over zero", {15'd0, pwm[0]}, 16'd0);
  endtask

  task automatic t_no_tick();
    settle_low();
    wr(8'h12, 16'd4); wr(8'h16, 16'h0030);
    step(16'd4, 1, 1, 1, 0); chk("R10 no tick", {15'd0, pwm[0]}, 16'd0);
    step(16'd4, 0, 0, 1, 1); chk("R10 tick acts", {15'd0, pwm[0]}, 16'd1);
  endtask

  task automatic t_force();
    wr(8'h1C, 16'h0001); chk("R11 A held low", {15'd0, pwm[0]}, 16'd0);
    step(16'd4, 0, 0, 1, 1); chk("R11 still low", {15'd0, pwm[0]}, 16'd0);
    wr(8'h1C, 16'h0000); chk("R11 release shows toggled", {15'd0, pwm[0]}, 16'd0);
    wr(8'h1C, 16'h0002); chk("R11 A held high", {15'd0, pwm[0]}, 16'd1);
    wr(8'h1C, 16'h0008); chk("R11 B held high", {14'd0, pwm}, 16'b10);
    wr(8'h1C, 16'h000F); chk("R11 code 3 no force", {14'd0, pwm}, 16'b00);
    wr(8'h1C, 16'h0004); chk("R11 B held low", {15'd0, pwm[1]}, 16'd0);
    wr(8'h1C, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_basic();
    t_zero_duty();
    t_shadow();
    t_frozen();
    t_toggle_down();
    t_priority();
    t_no_tick();
    t_force();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule